// File: doc/BRIEF.md
# Two-Mode Multiply-Accumulate Unit

This block is a 32x32 unsigned multiplier that sits next to a processor's register file. Its two operands arrive on dedicated input ports, which mirror two fixed processor registers. Software sees the unit through a window of three 32-bit registers, numbered 25, 26 and 27. Register 25 holds control and status. Registers 26 and 27 hold the low and high words of the current result. A byte-granular transfer command moves data between software and this window. A write command ("transfer-out") stores selected window bytes. A read command ("transfer-in") returns selected window bytes one cycle later.

The unit has two operating modes, and each is a state of a small state machine. In state ST_MULTIPLY the unit multiplies freely: every clock it registers the 64-bit product of the two operands and keeps the accumulator at zero. In state ST_ACCUMULATE the unit holds its result. Each accepted write that starts at register 25 samples the operands once and adds their product to a 64-bit accumulator. The new sum then shows on both the result and the accumulator outputs.

There are two transitions. ST_MULTIPLY goes to ST_ACCUMULATE when a write to byte 0 of register 25 carries a one in the mode bit. ST_ACCUMULATE goes to ST_MULTIPLY when such a write carries a zero there. A sticky carry flag records any 64-bit wrap of the accumulator. Writing a one to the flag clears it and zeroes the accumulator.

Top module: `macp_mac_unit`

## Requirements
- R1: After reset the unit is in multiply mode (mode_acc = 0), and prod_lo, prod_hi, acc_lo, acc_hi, carry, rd_valid and xfer_err are all zero.
- R2: In multiply mode the registered result {prod_hi, prod_lo} equals the unsigned 64-bit product of op_a and op_b from the previous clock, on every clock, and {acc_hi, acc_lo} stays zero.
- R3: In accumulate mode an accepted write whose start register is 25 adds op_a*op_b to the 64-bit accumulator at that clock edge, and the sum appears on both the result and the accumulator outputs. With no such write, both hold their values.
- R4: If an accumulate step wraps (the new sum is below the old one), carry is set. Carry stays set until it is explicitly cleared.
- R5: A write that includes byte 0 of register 25 with bit 1 (the carry bit) set clears carry and zeroes the accumulator. If the same write also triggers an accumulate, the clear happens first and the product is added to zero.
- R6: Bit 0 of register 25 is the mode bit (1 = accumulate). It changes only when a write includes byte 0 of register 25. A write that starts at register 25 byte 1 or later triggers an accumulate in accumulate mode but leaves the mode unchanged.
- R7: A transfer is rejected if any of these holds: its start register is below 25, its length is zero, or its last byte lies beyond byte 3 of register 27. A rejected transfer pulses xfer_err on the next clock, returns no read data, and changes no state.
- R8: An accepted read pulses rd_valid on the next clock. rd_data byte k is window byte k for each requested byte and zero otherwise. Window byte k means register 25+k/4, byte k%4. Register 25 reads as {30 zeros, carry, mode}, register 26 as prod_lo and register 27 as prod_hi.
- R9: Writes to bytes of registers 26 and 27 have no effect on the result or the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First multiplier operand |
| op_b | input | 32 | Second multiplier operand |
| xfer_valid | input | 1 | Transfer command present this cycle |
| xfer_write | input | 1 | 1 = write into window, 0 = read from window |
| xfer_reg | input | 5 | Start register number |
| xfer_byte | input | 2 | Start byte within the start register |
| xfer_len | input | 4 | Transfer length in bytes |
| xfer_wdata | input | 96 | Write data, byte k aligned to window byte k |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 96 | Read data, byte k = window byte k or zero |
| xfer_err | output | 1 | Previous transfer was rejected |
| prod_lo | output | 32 | Result low word |
| prod_hi | output | 32 | Result high word |
| acc_lo | output | 32 | Accumulator low word |
| acc_hi | output | 32 | Accumulator high word |
| mode_acc | output | 1 | 1 = accumulate mode |
| carry | output | 1 | Sticky accumulator wrap flag |

## Verification
The bench builds the unit with its default parameters: 32-bit operands and a window based at register 25 with 4-byte registers. The full 64-bit width lets squares of all-ones operands wrap the accumulator within two steps, so the carry set, sticky and clear paths are all covered in a few cycles. The 5-bit register number and 4-bit length let the bench exercise every rejection rule: a start below the window, a zero length, and a span that runs past the end of register 27.

// File: rtl/macp_pkg.sv
package macp_pkg;

    // Bit positions inside the control/status register (window register 0).
    localparam int MODE_BIT  = 0;
    localparam int CARRY_BIT = 1;

    // Operating mode of the unit, held as the state of the control FSM.
    typedef enum logic {
        ST_MULTIPLY   = 1'b0,
        ST_ACCUMULATE = 1'b1
    } mac_state_e;

endpackage

// File: rtl/macp_xfer_decode.sv
// Checks a transfer's start and length against the window and
// produces a per-byte enable for the bytes it covers.
module macp_xfer_decode #(
    parameter int REG_W     = 5,
    parameter int LEN_W     = 4,
    parameter int WIN_BASE  = 25,
    parameter int WIN_REGS  = 3,
    parameter int REG_BYTES = 4
) (
    input  logic [REG_W-1:0]               reg_idx,
    input  logic [$clog2(REG_BYTES)-1:0]   byte_idx,
    input  logic [LEN_W-1:0]               len,
    output logic                           in_range,
    output logic                           at_ctrl_reg,
    output logic [WIN_REGS*REG_BYTES-1:0]  byte_en
);
    localparam int BSEL_W    = $clog2(REG_BYTES);
    localparam int ABS_W     = REG_W + BSEL_W + 2;
    localparam int WIN_BYTES = WIN_REGS * REG_BYTES;
    localparam int LIMIT     = (WIN_BASE + WIN_REGS) * REG_BYTES;

    logic [ABS_W-1:0] start_abs;
    logic [ABS_W-1:0] end_abs;
    logic [ABS_W-1:0] rel_start;
    logic [ABS_W-1:0] rel_end;

    always_comb begin
        start_abs = ABS_W'(reg_idx) * ABS_W'(REG_BYTES) + ABS_W'(byte_idx);
        end_abs   = start_abs + ABS_W'(len);
        rel_start = start_abs - ABS_W'(WIN_BASE * REG_BYTES);
        rel_end   = rel_start + ABS_W'(len);
        in_range  = (reg_idx >= REG_W'(WIN_BASE))
                 && (len != '0)
                 && (end_abs <= ABS_W'(LIMIT));
        at_ctrl_reg = in_range && (reg_idx == REG_W'(WIN_BASE));
    end

    for (genvar k = 0; k < WIN_BYTES; k++) begin : g_byte_en
        assign byte_en[k] = in_range
                         && (ABS_W'(k) >= rel_start)
                         && (ABS_W'(k) <  rel_end);
    end

endmodule

// File: rtl/macp_datapath.sv
// Unsigned multiplier and 64-bit accumulate adder with wrap detect.
module macp_datapath #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]   mul_a,
    input  logic [OP_W-1:0]   mul_b,
    input  logic [2*OP_W-1:0] acc_base,
    output logic [2*OP_W-1:0] product,
    output logic [2*OP_W-1:0] sum,
    output logic              wrapped
);
    localparam int RES_W = 2 * OP_W;

    always_comb begin
        product = RES_W'(mul_a) * RES_W'(mul_b);
        sum     = acc_base + product;
        wrapped = (sum < acc_base);
    end

endmodule

// File: rtl/macp_mac_unit.sv
module macp_mac_unit #(
    parameter int OP_W     = 32,
    parameter int REG_W    = 5,
    parameter int LEN_W    = 4,
    parameter int WIN_BASE = 25
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [OP_W-1:0]              op_a,
    input  logic [OP_W-1:0]              op_b,
    input  logic                         xfer_valid,
    input  logic                         xfer_write,
    input  logic [REG_W-1:0]             xfer_reg,
    input  logic [1:0]                   xfer_byte,
    input  logic [LEN_W-1:0]             xfer_len,
    input  logic [3*OP_W-1:0]            xfer_wdata,
    output logic                         rd_valid,
    output logic [3*OP_W-1:0]            rd_data,
    output logic                         xfer_err,
    output logic [OP_W-1:0]              prod_lo,
    output logic [OP_W-1:0]              prod_hi,
    output logic [OP_W-1:0]              acc_lo,
    output logic [OP_W-1:0]              acc_hi,
    output logic                         mode_acc,
    output logic                         carry
);
    import macp_pkg::*;

    localparam int WIN_REGS  = 3;
    localparam int REG_BYTES = 4;
    localparam int WIN_BYTES = WIN_REGS * REG_BYTES;
    localparam int XFER_W    = WIN_BYTES * 8;
    localparam int RES_W     = 2 * OP_W;

    // ---------------- transfer decode ----------------
    logic                 dec_ok;
    logic                 dec_ctrl;
    logic [WIN_BYTES-1:0] dec_en;

    macp_xfer_decode #(
        .REG_W     (REG_W),
        .LEN_W     (LEN_W),
        .WIN_BASE  (WIN_BASE),
        .WIN_REGS  (WIN_REGS),
        .REG_BYTES (REG_BYTES)
    ) u_decode (
        .reg_idx     (xfer_reg),
        .byte_idx    (xfer_byte),
        .len         (xfer_len),
        .in_range    (dec_ok),
        .at_ctrl_reg (dec_ctrl),
        .byte_en     (dec_en)
    );

    logic wr_ok;
    logic rd_ok;
    logic ctrl_byte_wr;
    logic clr_req;
    logic step_req;

    always_comb begin
        wr_ok        = xfer_valid && xfer_write && dec_ok;
        rd_ok        = xfer_valid && !xfer_write && dec_ok;
        ctrl_byte_wr = wr_ok && dec_en[0];
        clr_req      = ctrl_byte_wr && xfer_wdata[CARRY_BIT];
        step_req     = wr_ok && dec_ctrl;
    end

    // ---------------- state machine ----------------
    mac_state_e state_q;
    mac_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MULTIPLY: begin
                if (ctrl_byte_wr && xfer_wdata[MODE_BIT])
                    state_d = ST_ACCUMULATE;
            end
            ST_ACCUMULATE: begin
                if (ctrl_byte_wr && !xfer_wdata[MODE_BIT])
                    state_d = ST_MULTIPLY;
            end
            default: state_d = ST_MULTIPLY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MULTIPLY;
        else        state_q <= state_d;
    end

    // ---------------- arithmetic ----------------
    logic [RES_W-1:0] prod_q, acc_q;
    logic             carry_q;
    logic [RES_W-1:0] acc_base;
    logic [RES_W-1:0] dp_product;
    logic [RES_W-1:0] dp_sum;
    logic             dp_wrap;

    // Clear is applied ahead of any addition in the same write.
    assign acc_base = clr_req ? '0 : acc_q;

    macp_datapath #(.OP_W(OP_W)) u_datapath (
        .mul_a    (op_a),
        .mul_b    (op_b),
        .acc_base (acc_base),
        .product  (dp_product),
        .sum      (dp_sum),
        .wrapped  (dp_wrap)
    );

    // ---------------- output / register process ----------------
    logic [RES_W-1:0] prod_d, acc_d;
    logic             carry_d;
    logic             carry_kept;

    always_comb begin
        carry_kept = carry_q && !clr_req;
        prod_d     = prod_q;
        acc_d      = acc_q;
        carry_d    = carry_kept;
        unique case (state_d)
            ST_MULTIPLY: begin
                prod_d = dp_product;
                acc_d  = '0;
            end
            ST_ACCUMULATE: begin
                if (step_req) begin
                    prod_d  = dp_sum;
                    acc_d   = dp_sum;
                    carry_d = carry_kept || dp_wrap;
                end
            end
            default: begin
                prod_d = dp_product;
                acc_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q  <= '0;
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            prod_q  <= prod_d;
            acc_q   <= acc_d;
            carry_q <= carry_d;
        end
    end

    // ---------------- read path ----------------
    logic [XFER_W-1:0] win_image;
    logic [XFER_W-1:0] rd_mask;
    logic [XFER_W-1:0] rd_data_q;
    logic              rd_valid_q;
    logic              err_q;

    assign win_image = {prod_q, {(OP_W-2){1'b0}}, carry_q, (state_q == ST_ACCUMULATE)};

    for (genvar k = 0; k < WIN_BYTES; k++) begin : g_rd_mask
        assign rd_mask[k*8 +: 8] = {8{dec_en[k]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            err_q      <= 1'b0;
        end else begin
            rd_valid_q <= rd_ok;
            rd_data_q  <= rd_ok ? (win_image & rd_mask) : '0;
            err_q      <= xfer_valid && !dec_ok;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign xfer_err = err_q;
    assign prod_lo  = prod_q[OP_W-1:0];
    assign prod_hi  = prod_q[RES_W-1:OP_W];
    assign acc_lo   = acc_q[OP_W-1:0];
    assign acc_hi   = acc_q[RES_W-1:OP_W];
    assign mode_acc = (state_q == ST_ACCUMULATE);
    assign carry    = carry_q;

    // ---------------- assertions ----------------
    a_r2_acc_zero_free: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MULTIPLY) |-> (acc_q == '0));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCUMULATE && !xfer_valid) |=> ($stable(prod_q) && $stable(acc_q)));

    a_r3_acc_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCUMULATE) |-> (prod_q == acc_q));

    a_r4_carry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_q && !(xfer_valid && xfer_write)) |=> carry_q);

    a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !dec_ok) |=> (xfer_err && !rd_valid && $stable(state_q) && $stable(carry_q)));

    a_r8_resp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && xfer_err));

endmodule

// File: tb/macp_mac_unit_test.sv
`timescale 1ns/1ps
module macp_mac_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        xfer_valid = 1'b0, xfer_write = 1'b0;
    logic [4:0]  xfer_reg = '0;
    logic [1:0]  xfer_byte = '0;
    logic [3:0]  xfer_len = '0;
    logic [95:0] xfer_wdata = '0;
    logic        rd_valid, xfer_err, mode_acc, carry;
    logic [95:0] rd_data;
    logic [31:0] prod_lo, prod_hi, acc_lo, acc_hi;

    always #2.5 clk = ~clk;

    macp_mac_unit uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .xfer_valid(xfer_valid), .xfer_write(xfer_write), .xfer_reg(xfer_reg),
        .xfer_byte(xfer_byte), .xfer_len(xfer_len), .xfer_wdata(xfer_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .xfer_err(xfer_err),
        .prod_lo(prod_lo), .prod_hi(prod_hi), .acc_lo(acc_lo), .acc_hi(acc_hi),
        .mode_acc(mode_acc), .carry(carry)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // {op_a, op_b, expected 64-bit product}
    localparam logic [127:0] MUL_VEC [8] = '{
        {32'h0000_0000, 32'h0000_0000, 64'h0000_0000_0000_0000},
        {32'h0000_0001, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFE_0000_0001},
        {32'h0001_0000, 32'h0001_0000, 64'h0000_0001_0000_0000},
        {32'h0000_0003, 32'h0000_0005, 64'h0000_0000_0000_000F},
        {32'h8000_0000, 32'h0000_0002, 64'h0000_0001_0000_0000},
        {32'h1234_5678, 32'h0000_0010, 64'h0000_0001_2345_6780},
        {32'h0000_FFFF, 32'h0000_FFFF, 64'h0000_0000_FFFE_0001}
    };

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [4:0] rg, input logic [1:0] by,
                        input logic [3:0] ln, input logic [95:0] wd);
        xfer_valid = 1'b1; xfer_write = wr; xfer_reg = rg;
        xfer_byte = by; xfer_len = ln; xfer_wdata = wd;
        @(negedge clk);
        xfer_valid = 1'b0; xfer_write = 1'b0; xfer_wdata = '0;
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 result", {32'h0, prod_hi, prod_lo}, 96'h0);
        chk("R1 acc", {32'h0, acc_hi, acc_lo}, 96'h0);
        chk("R1 flags", {92'h0, mode_acc, carry, rd_valid, xfer_err}, 96'h0);

        // R2 free-running multiply, table driven
        for (int i = 0; i < 8; i++) begin
            op_a = MUL_VEC[i][127:96];
            op_b = MUL_VEC[i][95:64];
            @(negedge clk);
            chk("R2 product", {32'h0, prod_hi, prod_lo}, {32'h0, MUL_VEC[i][63:0]});
            chk("R2 acc zero", {32'h0, acc_hi, acc_lo}, 96'h0);
        end

        // R6/R3 enter accumulate mode with first step
        op_a = 32'd3; op_b = 32'd5;
        xfer(1'b1, 5'd25, 2'd0, 4'd1, 96'h01);
        chk("R6 mode set", {95'h0, mode_acc}, 96'h1);
        chk("R3 first step result", {32'h0, prod_hi, prod_lo}, 96'd15);
        chk("R3 first step acc", {32'h0, acc_hi, acc_lo}, 96'd15);

        op_a = 32'd2; op_b = 32'd10;
        xfer(1'b1, 5'd25, 2'd0, 4'd1, 96'h01);
        chk("R3 second step", {32'h0, prod_hi, prod_lo}, 96'd35);

        op_a = 32'd9; op_b = 32'd9;
        repeat (3) @(negedge clk);
        chk("R3 hold", {32'h0, prod_hi, prod_lo}, 96'd35);

        // R9 writes to result registers ignored
        xfer(1'b1, 5'd26, 2'd0, 4'd8, 96'hCAFE_F00D_DEAD_BEEF_0000_0000);
        chk("R9 result unchanged", {32'h0, prod_hi, prod_lo}, 96'd35);
        chk("R9 acc unchanged", {32'h0, acc_hi, acc_lo}, 96'd35);

        // R8 full window read
        xfer(1'b0, 5'd25, 2'd0, 4'd12, 96'h0);
        chk("R8 full read valid", {95'h0, rd_valid}, 96'h1);
        chk("R8 full read data", rd_data, {32'h0, 32'd35, 32'h1});

        // R5 clear before add, R4 wrap and stickiness
        op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF;
        xfer(1'b1, 5'd25, 2'd0, 4'd1, 96'h03);
        chk("R5 clear then add", {32'h0, prod_hi, prod_lo}, {32'h0, 64'hFFFF_FFFE_0000_0001});
        chk("R5 carry low", {95'h0, carry}, 96'h0);
        xfer(1'b1, 5'd25, 2'd0, 4'd1, 96'h01);
        chk("R4 wrapped sum", {32'h0, acc_hi, acc_lo}, {32'h0, 64'hFFFF_FFFC_0000_0002});
        chk("R4 carry set", {95'h0, carry}, 96'h1);
        op_a = 32'd0; op_b = 32'd0;
        xfer(1'b1, 5'd25, 2'd0, 4'd1, 96'h01);
        chk("R4 carry sticky", {95'h0, carry}, 96'h1);
        chk("R4 sum kept", {32'h0, prod_hi, prod_lo}, {32'h0, 64'hFFFF_FFFC_0000_0002});

        // R8 partial reads
        xfer(1'b0, 5'd27, 2'd0, 4'd2, 96'h0);
        chk("R8 partial high", rd_data, {16'h0, 16'hFFFC, 64'h0});
        xfer(1'b0, 5'd25, 2'd0, 4'd1, 96'h0);
        chk("R8 status byte", rd_data, 96'h03);

        op_a = 32'd1; op_b = 32'd7;
        xfer(1'b1, 5'd25, 2'd0, 4'd1, 96'h03);
        chk("R5 carry cleared", {95'h0, carry}, 96'h0);
        chk("R5 restart sum", {32'h0, prod_hi, prod_lo}, 96'd7);

        // R7 rejections
        xfer(1'b1, 5'd24, 2'd0, 4'd4, 96'h0);
        chk("R7 below window err", {95'h0, xfer_err}, 96'h1);
        chk("R7 below window no change", {94'h0, mode_acc, carry}, 96'h2);
        xfer(1'b1, 5'd27, 2'd1, 4'd4, 96'h0);
        chk("R7 overrun err", {95'h0, xfer_err}, 96'h1);
        chk("R7 overrun result", {32'h0, prod_hi, prod_lo}, 96'd7);
        xfer(1'b1, 5'd25, 2'd0, 4'd0, 96'h0);
        chk("R7 zero length err", {95'h0, xfer_err}, 96'h1);
        chk("R7 zero length mode", {95'h0, mode_acc}, 96'h1);
        xfer(1'b0, 5'd24, 2'd3, 4'd2, 96'h0);
        chk("R7 read reject", {94'h0, rd_valid, xfer_err}, 96'h1);
        xfer(1'b0, 5'd27, 2'd3, 4'd1, 96'h0);
        chk("R7 last byte accepted", {94'h0, rd_valid, xfer_err}, 96'h2);

        // R6 write starting past the mode byte: steps, keeps mode
        op_a = 32'd1; op_b = 32'd1;
        xfer(1'b1, 5'd25, 2'd1, 4'd1, 96'hFF00);
        chk("R6 step without mode write", {32'h0, prod_hi, prod_lo}, 96'd8);
        chk("R6 mode kept", {95'h0, mode_acc}, 96'h1);

        // R6/R2 back to multiply mode
        op_a = 32'd4; op_b = 32'd6;
        xfer(1'b1, 5'd25, 2'd0, 4'd1, 96'h00);
        chk("R6 mode cleared", {95'h0, mode_acc}, 96'h0);
        chk("R2 product on return", {32'h0, prod_hi, prod_lo}, 96'd24);
        chk("R2 acc zero on return", {32'h0, acc_hi, acc_lo}, 96'h0);
        op_a = 32'd5; op_b = 32'd5;
        @(negedge clk);
        chk("R2 free run resumes", {32'h0, prod_hi, prod_lo}, 96'd25);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule